// File: doc/BRIEF.md
# Programmable Baud Rate Generator

This block turns a reference clock into the two strobes that a UART needs. The first is a sample-enable pulse at the oversampling rate. The second is a bit-enable pulse at the serial bit rate. Each strobe is one `clk` cycle wide.

The reference clock is divided in three stages:

1. A prescale stage. A mode bit adds a fixed divide-by-4. A 4-bit value N adds a divide-by-(N+1).
2. A 16-bit programmable divisor. Software loads it one byte at a time.
3. An oversampling stage. It emits one bit strobe for every 16, 8 or 4 sample strobes.

All settings arrive through a small register-write port. Every write restarts the whole chain, so a new rate takes effect immediately and with a known phase.

For example, take a 1.8432 MHz reference with no prescaling and 16× oversampling. A divisor of 12 then gives 9600 bit/s, a divisor of 1 gives 115200 bit/s, and a divisor of 0x0900 gives 50 bit/s.

Top module: `baud_tick_gen`

## Requirements

In these requirements, P is the prescale ratio, D is the divisor and R is the oversampling ratio.

- R1: While `rst_n` is low, and afterwards until a nonzero divisor is written, `sample_en_o` and `bit_en_o` stay low. The reset value of every setting is zero.
- R2: The divisor is written one byte at a time:
  - `wr_sel` = 0 writes the low byte.
  - `wr_sel` = 1 writes the high byte.
  - With D nonzero, `sample_en_o` pulses once every P·D clock cycles.
- R3: A divisor of 0 stops `sample_en_o`, and with it `bit_en_o`. Neither strobe pulses again until a nonzero divisor is written.
- R4: The sampling-rate field is bits [2:1] of the config register (`wr_sel` = 3). It sets the oversampling ratio R:
  - Code 00 gives 16.
  - Code 01 gives 8.
  - Codes 10 and 11 give 4.
  - `bit_en_o` pulses together with every R-th `sample_en_o` pulse, so R sample pulses fall in each bit period.
- R5: A prescaler value N is written to `wr_data[3:0]` with `wr_sel` = 2. It divides the reference clock by N+1 ahead of the divisor. N = 0 means no division.
- R6: Bit 0 of the config register is the quarter-rate mode bit. When it is 1, the reference clock is divided by 4 as well. Together with N, the prescale ratio becomes P = 4·(N+1).
- R7: Any register write clears both outputs in the following cycle and restarts every counter. Counting from the clock edge that accepts the write:
  - The first `sample_en_o` pulse comes P·D edges later.
  - The first `bit_en_o` pulse comes P·D·R edges later.
- R8: `bit_en_o` is never high unless `sample_en_o` is high in the same cycle.
- R9: With P = 1 and R = 16, the bit period is 16·D reference cycles:
  - D = 12 gives 192 cycles, which is 9600 bit/s from 1.8432 MHz.
  - D = 0x0180 gives 6144 cycles, which is 300 bit/s.

## Ports

| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select: 0 divisor low byte, 1 divisor high byte, 2 prescaler, 3 config |
| wr_data | input | 8 | Write data |
| sample_en_o | output | 1 | One-cycle oversampling strobe |
| bit_en_o | output | 1 | One-cycle bit-rate strobe |

## Verification

The bench builds the block with its default parameters: a 16-bit divisor, a 4-bit prescaler and the prescale stage present. Because of that, it can sweep all 32 combinations of prescaler value and quarter-rate mode, and the divisor from 1 to 48. It also visits every sampling code. For each setting it measures three things against the arithmetic P·D and P·D·R:

- the delay from the write to the first sample strobe;
- the delay from the write to the first bit strobe;
- the number of sample strobes in each bit period.

Beyond the sweeps, it checks the reference divisors (12, 0x0180 and 0x0417), a stop with a zero divisor, and a reload in the middle of a count through each divisor byte.

// File: rtl/bg_pkg.sv
package bg_pkg;

   localparam int OS_MAX   = 16;
   localparam int OS_CNT_W = $clog2(OS_MAX);

   typedef enum logic [1:0] {
      REG_DIV_LO = 2'd0,
      REG_DIV_HI = 2'd1,
      REG_PRE    = 2'd2,
      REG_CFG    = 2'd3
   } reg_sel_e;

   typedef enum logic [1:0] {
      OS_X16  = 2'b00,
      OS_X8   = 2'b01,
      OS_X4   = 2'b10,
      OS_X4_B = 2'b11
   } os_sel_e;

   function automatic logic [OS_CNT_W-1:0] os_last(input os_sel_e sel);
      case (sel)
         OS_X16:  os_last = OS_CNT_W'(15);
         OS_X8:   os_last = OS_CNT_W'(7);
         default: os_last = OS_CNT_W'(3);
      endcase
   endfunction

endpackage

// File: rtl/bg_prescale.sv
module bg_prescale #(
   parameter int PRE_W         = 4,
   parameter bit HAS_PRESCALER = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             restart,
   input  logic             quarter,
   input  logic [PRE_W-1:0] pre_val,
   output logic             tick
);

   localparam int CNT_W = PRE_W + 3;

   logic [CNT_W-1:0] base;
   logic [CNT_W-1:0] limit;
   logic [CNT_W-1:0] cnt_q;

   generate
      if (HAS_PRESCALER) begin : g_full
         always_comb base = CNT_W'(pre_val) + CNT_W'(1);
      end else begin : g_quarter_only
         logic unused_pre;
         always_comb unused_pre = ^pre_val;
         always_comb base = CNT_W'(1);
      end
   endgenerate

   always_comb begin
      limit = quarter ? ((base << 2) - CNT_W'(1)) : (base - CNT_W'(1));
      tick  = (cnt_q == limit);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         cnt_q <= '0;
      else if (restart)   cnt_q <= '0;
      else if (tick)      cnt_q <= '0;
      else                cnt_q <= cnt_q + CNT_W'(1);
   end

   // R5
   pre_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= limit);

endmodule

// File: rtl/bg_divider.sv
module bg_divider #(
   parameter int DIV_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             restart,
   input  logic             tick_in,
   input  logic [DIV_W-1:0] divisor,
   output logic             samp
);

   logic [DIV_W-1:0] dc_q;
   logic             at_end;
   logic             active;

   always_comb begin
      active = (divisor != '0);
      at_end = (dc_q == divisor - DIV_W'(1));
      samp   = tick_in && active && at_end;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 dc_q <= '0;
      else if (restart)           dc_q <= '0;
      else if (tick_in && active) dc_q <= at_end ? '0 : dc_q + DIV_W'(1);
   end

   // R2
   div_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (divisor == '0) || (dc_q < divisor));

endmodule

// File: rtl/bg_oversample.sv
module bg_oversample
   import bg_pkg::*;
(
   input  logic    clk,
   input  logic    rst_n,
   input  logic    restart,
   input  logic    samp_in,
   input  os_sel_e os_sel,
   output logic    sample_en_o,
   output logic    bit_en_o
);

   logic [OS_CNT_W-1:0] oc_q;
   logic [OS_CNT_W-1:0] last;

   always_comb last = os_last(os_sel);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         oc_q <= '0;
      else if (restart)   oc_q <= '0;
      else if (samp_in)   oc_q <= (oc_q == last) ? '0 : oc_q + OS_CNT_W'(1);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sample_en_o <= 1'b0;
         bit_en_o    <= 1'b0;
      end else if (restart) begin
         sample_en_o <= 1'b0;
         bit_en_o    <= 1'b0;
      end else begin
         sample_en_o <= samp_in;
         bit_en_o    <= samp_in && (oc_q == last);
      end
   end

   // R4
   os_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      oc_q <= last);

   // R8
   bit_in_sample_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bit_en_o |-> sample_en_o);

endmodule

// File: rtl/baud_tick_gen.sv
module baud_tick_gen
   import bg_pkg::*;
#(
   parameter int BYTE_W        = 8,
   parameter int DIV_W         = 16,
   parameter int PRE_W         = 4,
   parameter bit HAS_PRESCALER = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [1:0]        wr_sel,
   input  logic [BYTE_W-1:0] wr_data,
   output logic              sample_en_o,
   output logic              bit_en_o
);

   generate
      if (DIV_W != 2 * BYTE_W) begin : g_bad_div
         $error("DIV_W must equal two register bytes");
      end
      if (PRE_W > BYTE_W || PRE_W < 1) begin : g_bad_pre
         $error("PRE_W must fit in one register byte");
      end
      if (BYTE_W < 3) begin : g_bad_byte
         $error("config register needs three bits");
      end
   endgenerate

   logic [DIV_W-1:0] div_q;
   logic [PRE_W-1:0] pre_q;
   logic             quarter_q;
   os_sel_e          os_q;
   logic             pre_tick;
   logic             samp;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         div_q     <= '0;
         pre_q     <= '0;
         quarter_q <= 1'b0;
         os_q      <= OS_X16;
      end else if (wr_en) begin
         case (reg_sel_e'(wr_sel))
            REG_DIV_LO: div_q[BYTE_W-1:0]     <= wr_data;
            REG_DIV_HI: div_q[DIV_W-1:BYTE_W] <= wr_data;
            REG_PRE:    pre_q                 <= wr_data[PRE_W-1:0];
            default: begin
               quarter_q <= wr_data[0];
               os_q      <= os_sel_e'(wr_data[2:1]);
            end
         endcase
      end
   end

   bg_prescale #(.PRE_W(PRE_W), .HAS_PRESCALER(HAS_PRESCALER)) u_pre (
      .clk     (clk),
      .rst_n   (rst_n),
      .restart (wr_en),
      .quarter (quarter_q),
      .pre_val (pre_q),
      .tick    (pre_tick)
   );

   bg_divider #(.DIV_W(DIV_W)) u_div (
      .clk     (clk),
      .rst_n   (rst_n),
      .restart (wr_en),
      .tick_in (pre_tick),
      .divisor (div_q),
      .samp    (samp)
   );

   bg_oversample u_os (
      .clk         (clk),
      .rst_n       (rst_n),
      .restart     (wr_en),
      .samp_in     (samp),
      .os_sel      (os_q),
      .sample_en_o (sample_en_o),
      .bit_en_o    (bit_en_o)
   );

   // R3
   zero_div_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (div_q == '0) && $past(div_q == '0) |-> !sample_en_o && !bit_en_o);

   // R7
   restart_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> !sample_en_o && !bit_en_o);

endmodule

// File: tb/baud_tick_gen_test.sv
`timescale 1ns/1ps
module baud_tick_gen_test;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic [1:0] wr_sel = 2'd0;
   logic [7:0] wr_data = 8'd0;
   logic       sample_en_o;
   logic       bit_en_o;

   int vectors = 0;
   int fails   = 0;
   bit done    = 1'b0;

   always #10 clk = ~clk;

   baud_tick_gen uut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
      .wr_data(wr_data), .sample_en_o(sample_en_o), .bit_en_o(bit_en_o)
   );

   task automatic chk(input string req, input int act, input int exp);
      vectors++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] sel, input logic [7:0] data);
      @(negedge clk);
      wr_en = 1'b1; wr_sel = sel; wr_data = data;
      @(posedge clk);
      #1 wr_en = 1'b0;
   endtask

   function automatic int ratio(input int code);
      return (code == 0) ? 16 : (code == 1) ? 8 : 4;
   endfunction

   // program everything; the last write (high byte) is the restart edge
   task automatic setup(input int n, input int q, input int code, input int d);
      wr(2'd2, 8'(n));
      wr(2'd3, 8'((code << 1) | q));
      wr(2'd0, 8'(d & 8'hFF));
      wr(2'd1, 8'(d >> 8));
   endtask

   // count edges from the restart edge to the first bit strobe
   task automatic measure(input string req, input int p, input int d, input int r);
      int n = 0, samples = 0, first = 0, stray = 0;
      int limit = p * d * r + 50;
      do begin
         @(posedge clk); n++;
         @(negedge clk);
         if (sample_en_o) begin
            samples++;
            if (first == 0) first = n;
         end
         if (bit_en_o && !sample_en_o) stray++;
      end while (!bit_en_o && n < limit);
      chk({req, " R7 first sample delay"}, first, p * d);
      chk({req, " R4 bit delay"}, n, p * d * r);
      chk({req, " R4 samples per bit"}, samples, r);
      chk("R8 bit without sample", stray, 0);
   endtask

   task automatic period(input string req, input int exp);
      int n = 0;
      do begin
         @(posedge clk); n++;
         @(negedge clk);
      end while (!sample_en_o && n < exp + 50);
      chk(req, n, exp);
   endtask

   initial begin
      int cyc = 0;
      while (!done && cyc < 190000) begin
         @(posedge clk); cyc++;
      end
      if (!done) begin
         fails++;
         vectors++;
         $display("FAIL watchdog actual=%0d expected<190000", cyc);
         $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
         $finish;
      end
   end

   initial begin
      int hits;
      // R1 reset state
      repeat (3) @(negedge clk);
      chk("R1 sample in reset", int'(sample_en_o), 0);
      chk("R1 bit in reset", int'(bit_en_o), 0);
      rst_n = 1'b1;
      hits = 0;
      for (int i = 0; i < 200; i++) begin
         @(negedge clk);
         if (sample_en_o || bit_en_o) hits++;
      end
      chk("R1 idle after reset", hits, 0);

      // R5 R6 exhaustive prescaler and quarter-rate sweep
      for (int q = 0; q < 2; q++)
         for (int n = 0; n < 16; n++) begin
            setup(n, q, 2, 1);
            measure(q ? "R6 quarter" : "R5 prescale", (q ? 4 : 1) * (n + 1), 1, 4);
         end

      // R2 divisor sweep, 8x
      for (int d = 1; d <= 48; d++) begin
         setup(0, 0, 1, d);
         measure("R2 divisor", 1, d, 8);
         period("R2 sample period", d);
      end

      // R4 every sampling code with a prescaled divisor
      for (int c = 0; c < 4; c++) begin
         setup(2, 1, c, 3);
         measure("R4 code", 12, 3, ratio(c));
      end

      // R9 reference divisors at 16x
      setup(0, 0, 0, 12);
      measure("R9 9600", 1, 12, 16);
      setup(0, 0, 0, 'h0180);
      measure("R9 300", 1, 'h0180, 16);
      setup(0, 0, 0, 'h0417);
      measure("R9 110", 1, 'h0417, 16);

      // R3 zero divisor stops output
      setup(0, 0, 0, 5);
      wr(2'd0, 8'h00);
      hits = 0;
      for (int i = 0; i < 300; i++) begin
         @(negedge clk);
         if (sample_en_o || bit_en_o) hits++;
      end
      chk("R3 divisor zero", hits, 0);
      wr(2'd0, 8'h07);
      measure("R3 resume", 1, 7, 16);

      // R7 reload in the middle of a count through each byte
      setup(0, 0, 0, 100);
      repeat (30) @(negedge clk);
      wr(2'd0, 8'h05);
      period("R7 reload low byte", 5);
      setup(0, 0, 0, 200);
      repeat (40) @(negedge clk);
      wr(2'd1, 8'h00);
      measure("R7 reload high byte", 1, 200 & 8'hFF, 16);

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end

endmodule